// File: doc/BRIEF.md
# Host / Management Controller Mailbox Register File

This block is a small register file shared by two agents: a host processor and a management controller. Each agent has its own byte-wide register port with an address, a write enable, write data and combinational read data. Both ports run on one clock. Either agent can read every register. Reading never changes any state.

The bank holds sixteen message bytes. Offsets 0x00 to 0x0E carry the message, and offset 0x0F is the attention byte. Above them sit two status bytes, a control byte for each side and four interrupt-enable bytes. Offset k (0 to 15) has its own sticky status bit k. A write from the management port to that offset sets the bit. Either port clears it by writing a 1. This way the response byte at offset 13 and the attention byte at 0x0F raise host-visible events.

Each control byte contains a doorbell. The doorbell is a two-state machine with states DB_IDLE and DB_RAISED. The transition RING (DB_IDLE to DB_RAISED) happens on a write with the ping bit set. The transition ACK (DB_RAISED to DB_IDLE) happens on a write with the status bit set and the ping bit clear. Otherwise the machine holds its state (HOLD). A raised doorbell interrupts the opposite agent unless that agent has set the mask bit in its own control byte.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset every offset reads 0x00 on both ports, and `host_irq` and `mgmt_irq` are low.
- R2: Offsets 0x00–0x0F and 0x14–0x17 store the written byte, and either port reads it back. If both ports write the same offset in one cycle, the management port's data is kept.
- R3: A management-port write to offset k (0–15) sets status bit k. Bits 0–7 appear in 0x10 bit k. Bits 8–15 appear in 0x11 bit k−8, so offset 13 sets 0x11 bit 5 and offset 0x0F sets 0x11 bit 7. Host-port writes to these offsets set nothing.
- R4: Writing 0x10 or 0x11 from either port clears each status bit written as 1. Bits written as 0 keep their value.
- R5: When a set and a clear of the same status bit land in the same cycle, the bit ends up set.
- R6: `host_irq` is high when any status bit of 0x10 is set with the same bit of 0x16 set, or when any bit of 0x11 is set with the same bit of 0x17 set. `host_irq` is also high while the doorbell in 0x12 is raised and 0x13 bit 1 is clear.
- R7: A write to 0x13 with bit 0 set raises the doorbell in 0x13, and 0x13 bit 7 then reads 1. While it is raised and 0x12 bit 1 is clear, `mgmt_irq` is high. Writing 0x03 to 0x13 reads back as 0x82.
- R8: A write to a control byte with bit 7 set and bit 0 clear lowers that byte's doorbell. If bit 0 is also set, the doorbell stays raised.
- R9: A write to 0x12 with bit 0 set raises the doorbell in 0x12, which reads as 0x12 bit 7 and drives `host_irq` as given in R6.
- R10: Offsets 0x18–0x1F read 0x00 and ignore writes. Reads of any offset leave all state unchanged.
- R11: Control bits 6..1 store the written value. Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | AW | Host port register offset |
| h_we | input | 1 | Host port write enable |
| h_wdata | input | DW | Host port write data |
| h_rdata | output | DW | Host port read data (combinational) |
| m_addr | input | AW | Management port register offset |
| m_we | input | 1 | Management port write enable |
| m_wdata | input | DW | Management port write data |
| m_rdata | output | DW | Management port read data (combinational) |
| host_irq | output | 1 | Interrupt toward the host |
| mgmt_irq | output | 1 | Interrupt toward the management controller |

## Verification
The bench builds the block with its default DW = 8 and AW = 5. With these values the whole 32-entry address space is small enough to sweep, including the eight unmapped offsets. Each of the sixteen status bits is set, cleared and interrupt-gated one at a time, with the expected mask computed as a shifted run of ones. All 64 patterns of the stored control bits are written and read back. Collisions between the two ports, and a set landing together with a clear, are driven as cycle-exact simultaneous writes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Doorbell machine states
    typedef enum logic {
        DB_IDLE   = 1'b0,
        DB_RAISED = 1'b1
    } db_state_e;

    // Bit positions inside a control byte
    localparam int CB_PING = 0;
    localparam int CB_MASK = 1;

endpackage

// File: rtl/mbx_wdec.sv
module mbx_wdec #(
    parameter int AW   = 5,
    parameter int NREG = 24
) (
    input  logic [AW-1:0]   addr,
    input  logic            we,
    output logic [NREG-1:0] sel
);

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            sel[i] = we && (addr == AW'(i));
        end
    end

endmodule

// File: rtl/mbx_status_bank.sv
module mbx_status_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_o[k] <= 1'b0;
            end else if (set_i[k]) begin
                stat_o[k] <= 1'b1;     // a set beats a same-cycle clear
            end else if (clr_i[k]) begin
                stat_o[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ping_i,
    input  logic ack_i,
    input  logic mask_i,
    output logic pend_o,
    output logic irq_o
);

    db_state_e state_q;
    db_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: RING, ACK, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_IDLE: begin
                if (ping_i) begin
                    state_d = DB_RAISED;
                end
            end
            DB_RAISED: begin
                if (ack_i && !ping_i) begin
                    state_d = DB_IDLE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == DB_RAISED);
        irq_o  = pend_o && !mask_i;
    end

endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] h_addr,
    input  logic          h_we,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [AW-1:0] m_addr,
    input  logic          m_we,
    input  logic [DW-1:0] m_wdata,
    output logic [DW-1:0] m_rdata,
    output logic          host_irq,
    output logic          mgmt_irq
);

    localparam int NMSG  = 2 * DW;        // message bytes incl. attention byte
    localparam int NSTAT = NMSG;          // one status bit per message byte
    localparam int O_ST0 = NMSG;
    localparam int O_ST1 = NMSG + 1;
    localparam int O_MC  = NMSG + 2;      // management-side control
    localparam int O_HC  = NMSG + 3;      // host-side control
    localparam int O_EN  = NMSG + 4;      // first enable byte
    localparam int NEN   = 4;
    localparam int NREG  = O_EN + NEN;

    // Write strobes per port
    logic [NREG-1:0] h_sel;
    logic [NREG-1:0] m_sel;

    mbx_wdec #(.AW(AW), .NREG(NREG)) u_hdec (.addr(h_addr), .we(h_we), .sel(h_sel));
    mbx_wdec #(.AW(AW), .NREG(NREG)) u_mdec (.addr(m_addr), .we(m_we), .sel(m_sel));

    // Plain storage
    logic [DW-1:0] msg_q [NMSG];
    logic [DW-1:0] en_q  [NEN];
    logic [DW-2:1] mctl_q;
    logic [DW-2:1] hctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NMSG; i++) begin
                msg_q[i] <= '0;
            end
            for (int i = 0; i < NEN; i++) begin
                en_q[i] <= '0;
            end
            mctl_q <= '0;
            hctl_q <= '0;
        end else begin
            for (int i = 0; i < NMSG; i++) begin
                if (m_sel[i]) begin
                    msg_q[i] <= m_wdata;
                end else if (h_sel[i]) begin
                    msg_q[i] <= h_wdata;
                end
            end
            for (int i = 0; i < NEN; i++) begin
                if (m_sel[O_EN+i]) begin
                    en_q[i] <= m_wdata;
                end else if (h_sel[O_EN+i]) begin
                    en_q[i] <= h_wdata;
                end
            end
            if (m_sel[O_MC]) begin
                mctl_q <= m_wdata[DW-2:1];
            end else if (h_sel[O_MC]) begin
                mctl_q <= h_wdata[DW-2:1];
            end
            if (m_sel[O_HC]) begin
                hctl_q <= m_wdata[DW-2:1];
            end else if (h_sel[O_HC]) begin
                hctl_q <= h_wdata[DW-2:1];
            end
        end
    end

    // Sticky status: set by management writes to message bytes, cleared by writing 1
    logic [NSTAT-1:0] stat_set;
    logic [NSTAT-1:0] stat_clr;
    logic [NSTAT-1:0] stat_q;

    always_comb begin
        stat_set = m_sel[NMSG-1:0];
        stat_clr[DW-1:0]     = (h_sel[O_ST0] ? h_wdata : '0) | (m_sel[O_ST0] ? m_wdata : '0);
        stat_clr[NSTAT-1:DW] = (h_sel[O_ST1] ? h_wdata : '0) | (m_sel[O_ST1] ? m_wdata : '0);
    end

    mbx_status_bank #(.N(NSTAT)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stat_set),
        .clr_i  (stat_clr),
        .stat_o (stat_q)
    );

    // Doorbells: side 0 lives in the management control byte, side 1 in the host one
    logic [1:0] db_ping;
    logic [1:0] db_ack;
    logic [1:0] db_mask;
    logic [1:0] db_pend;
    logic [1:0] db_irq;

    assign db_mask[0] = hctl_q[CB_MASK];   // host masks the management doorbell
    assign db_mask[1] = mctl_q[CB_MASK];   // management masks the host doorbell

    for (genvar s = 0; s < 2; s++) begin : g_db
        localparam int OFF = O_MC + s;
        assign db_ping[s] = (h_sel[OFF] && h_wdata[CB_PING]) || (m_sel[OFF] && m_wdata[CB_PING]);
        assign db_ack[s]  = (h_sel[OFF] && h_wdata[DW-1])    || (m_sel[OFF] && m_wdata[DW-1]);

        mbx_doorbell u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .ping_i (db_ping[s]),
            .ack_i  (db_ack[s]),
            .mask_i (db_mask[s]),
            .pend_o (db_pend[s]),
            .irq_o  (db_irq[s])
        );
    end

    // Interrupts
    logic [NSTAT-1:0] hen;
    assign hen      = {en_q[3], en_q[2]};
    assign host_irq = (|(stat_q & hen)) || db_irq[0];
    assign mgmt_irq = db_irq[1];

    // Read view
    logic [DW-1:0] view [NREG];

    always_comb begin
        for (int i = 0; i < NMSG; i++) begin
            view[i] = msg_q[i];
        end
        view[O_ST0] = stat_q[DW-1:0];
        view[O_ST1] = stat_q[NSTAT-1:DW];
        view[O_MC]  = {db_pend[0], mctl_q, 1'b0};
        view[O_HC]  = {db_pend[1], hctl_q, 1'b0};
        for (int i = 0; i < NEN; i++) begin
            view[O_EN+i] = en_q[i];
        end
    end

    assign h_rdata = (int'(h_addr) < NREG) ? view[h_addr] : '0;
    assign m_rdata = (int'(m_addr) < NREG) ? view[m_addr] : '0;

endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   h_addr,
    input logic            h_we,
    input logic [DW-1:0]   h_wdata,
    input logic [DW-1:0]   h_rdata,
    input logic [AW-1:0]   m_addr,
    input logic            m_we,
    input logic            host_irq,
    input logic            mgmt_irq,
    input logic [2*DW-1:0] stat,
    input logic [2*DW-1:0] hen,
    input logic [1:0]      pend
);

    localparam int NMSG = 2 * DW;
    localparam int NREG = NMSG + 8;
    localparam logic [AW-1:0] A_RESP = AW'(NMSG - 3);
    localparam logic [AW-1:0] A_FLAG = AW'(NMSG - 1);
    localparam logic [AW-1:0] A_ST1  = AW'(NMSG + 1);
    localparam logic [AW-1:0] A_HC   = AW'(NMSG + 3);

    // R1: interrupts quiet when reset releases
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!host_irq && !mgmt_irq));

    // R3: management write to the response byte raises its status bit
    p_resp_sets_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we && m_addr == A_RESP) |=> stat[NMSG-3]);

    // R4: write-one clears the attention bit when no set competes
    p_attn_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == A_ST1 && h_wdata[DW-1] && !(m_we && m_addr == A_FLAG))
        |=> !stat[NMSG-1]);

    // R5: set beats a same-cycle clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we && m_addr == A_FLAG && h_we && h_addr == A_ST1 && h_wdata[DW-1])
        |=> stat[NMSG-1]);

    // R6: host interrupt only with an enabled cause
    p_host_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> ((|(stat & hen)) || pend[0]));

    // R7: host ping raises the host-side doorbell
    p_host_ping_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == A_HC && h_wdata[0]) |=> pend[1]);

    // R7: management interrupt needs a raised host doorbell
    p_mgmt_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_irq |-> pend[1]);

    // R10: unmapped offsets read zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(h_addr) >= NREG) |-> (h_rdata == '0));

endmodule

bind mbx_mailbox mbx_mailbox_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_addr   (h_addr),
    .h_we     (h_we),
    .h_wdata  (h_wdata),
    .h_rdata  (h_rdata),
    .m_addr   (m_addr),
    .m_we     (m_we),
    .host_irq (host_irq),
    .mgmt_irq (mgmt_irq),
    .stat     (stat_q),
    .hen      (hen),
    .pend     (db_pend)
);

// File: tb/tb_mbx_mailbox.sv
module tb_mbx_mailbox;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] h_addr = '0;
    logic       h_we = 1'b0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic [4:0] m_addr = '0;
    logic       m_we = 1'b0;
    logic [7:0] m_wdata = '0;
    logic [7:0] m_rdata;
    logic       host_irq;
    logic       mgmt_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mbx_mailbox #(.DW(8), .AW(5)) dut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .host_irq(host_irq), .mgmt_irq(mgmt_irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic hw(input int a, input int d);
        @(negedge clk);
        h_addr = 5'(a); h_wdata = 8'(d); h_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic mw(input int a, input int d);
        @(negedge clk);
        m_addr = 5'(a); m_wdata = 8'(d); m_we = 1'b1;
        @(negedge clk);
        m_we = 1'b0;
    endtask

    task automatic bw(input int ha, input int hd, input int ma, input int md);
        @(negedge clk);
        h_addr = 5'(ha); h_wdata = 8'(hd); h_we = 1'b1;
        m_addr = 5'(ma); m_wdata = 8'(md); m_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0; m_we = 1'b0;
    endtask

    task automatic hr(input int a, output int v);
        h_addr = 5'(a); #1; v = int'(h_rdata);
    endtask

    task automatic mr(input int a, output int v);
        m_addr = 5'(a); #1; v = int'(m_rdata);
    endtask

    task automatic rd_stat(output int v);
        int lo, hi;
        hr(16, lo); hr(17, hi);
        v = (hi << 8) | lo;
    endtask

    function automatic int pat(input int a);
        return (a * 37 + 11) & 255;
    endfunction

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        int st;
        repeat (3) @(negedge clk);
        // R1: reset state on every offset, both ports
        for (int a = 0; a < 32; a++) begin
            hr(a, v); chk("R1 host read", v, 0);
            mr(a, v); chk("R1 mgmt read", v, 0);
        end
        chk("R1 host_irq", int'(host_irq), 0);
        chk("R1 mgmt_irq", int'(mgmt_irq), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: storage via host port, readback both ports; R3: host writes set no status
        for (int a = 0; a < 24; a++) begin
            if (a < 16 || a >= 20) hw(a, pat(a));
        end
        for (int a = 0; a < 24; a++) begin
            if (a < 16 || a >= 20) begin
                hr(a, v); chk("R2 host readback", v, pat(a));
                mr(a, v); chk("R2 mgmt readback", v, pat(a));
            end
        end
        rd_stat(st); chk("R3 host writes set no status", st, 0);
        for (int a = 20; a < 24; a++) hw(a, 0);

        // R3: management write to offset k sets status bit k
        for (int k = 0; k < 16; k++) begin
            mw(k, pat(k) ^ 8'hA5);
            rd_stat(st); chk("R3 status accumulate", st, (1 << (k + 1)) - 1);
            hr(k, v); chk("R2 mgmt data stored", v, pat(k) ^ 8'hA5);
        end

        // R4: zeros leave status alone, ones clear single bits
        hw(16, 0); mw(17, 0);
        rd_stat(st); chk("R4 zero write keeps", st, 16'hFFFF);
        for (int k = 0; k < 16; k++) begin
            if (k % 2 == 0) hw(16 + k / 8, 1 << (k % 8));
            else            mw(16 + k / 8, 1 << (k % 8));
            rd_stat(st); chk("R4 w1c sweep", st, (16'hFFFF << (k + 1)) & 16'hFFFF);
        end

        // R6: per-bit interrupt gating by host enables
        for (int k = 0; k < 16; k++) begin
            mw(k, k);
            #1 chk("R6 irq off with enables zero", int'(host_irq), 0);
            hw(22 + k / 8, (~(1 << (k % 8))) & 255);
            #1 chk("R6 irq off with other enables", int'(host_irq), 0);
            hw(22 + k / 8, 1 << (k % 8));
            #1 chk("R6 irq on matching enable", int'(host_irq), 1);
            hw(16 + k / 8, 1 << (k % 8));
            #1 chk("R6 irq off after clear", int'(host_irq), 0);
            hw(22 + k / 8, 0);
        end

        // R5: set on bit 13 together with clear of bits 13 and 15
        mw(15, 8'h3C);
        bw(17, 8'hA0, 13, 8'h55);
        hr(17, v); chk("R5 set wins, other bit cleared", v, 8'h20);
        hr(13, v); chk("R5 response byte data", v, 8'h55);
        hw(17, 8'hFF);

        // R2: same-offset collision keeps management data
        bw(3, 8'h11, 3, 8'h22);
        mr(3, v); chk("R2 collision mgmt wins", v, 8'h22);
        hw(16, 8'hFF);
        rd_stat(st); chk("R4 status clean", st, 0);

        // R7 / R8: host doorbell toward the management side
        hw(19, 8'h03);
        hr(19, v); chk("R7 host ctrl readback", v, 8'h82);
        #1 chk("R7 mgmt_irq raised", int'(mgmt_irq), 1);
        mw(18, 8'h02);
        #1 chk("R7 mgmt mask gates irq", int'(mgmt_irq), 0);
        hr(19, v); chk("R7 pending kept under mask", v, 8'h82);
        mw(18, 8'h00);
        #1 chk("R7 unmask re-raises irq", int'(mgmt_irq), 1);
        hw(19, 8'h81);
        hr(19, v); chk("R8 ping with ack keeps pending", v, 8'h80);
        hw(19, 8'h80);
        hr(19, v); chk("R8 ack lowers doorbell", v, 8'h00);
        #1 chk("R8 mgmt_irq low after ack", int'(mgmt_irq), 0);

        // R9: management doorbell toward the host
        mw(18, 8'h01);
        mr(18, v); chk("R9 mgmt ctrl pending", v, 8'h80);
        #1 chk("R9 host_irq raised", int'(host_irq), 1);
        chk("R9 mgmt_irq stays low", int'(mgmt_irq), 0);
        hw(19, 8'h02);
        #1 chk("R9 host mask gates irq", int'(host_irq), 0);
        hw(19, 8'h00);
        #1 chk("R9 unmask re-raises", int'(host_irq), 1);
        mw(18, 8'h80);
        #1 chk("R9 ack lowers host_irq", int'(host_irq), 0);

        // R11: all patterns of control bits 6..1
        for (int d = 0; d < 64; d++) begin
            if (d % 2 == 0) hw(18, d << 1);
            else            mw(19, d << 1);
            if (d % 2 == 0) begin
                mr(18, v); chk("R11 mgmt ctrl bits", v, d << 1);
            end else begin
                hr(19, v); chk("R11 host ctrl bits", v, d << 1);
            end
        end
        hw(18, 0); hw(19, 0);
        #1 chk("R11 no stray irq", int'(host_irq | mgmt_irq), 0);

        // R10: unmapped offsets, reads without side effects
        for (int a = 24; a < 32; a++) begin
            hw(a, 8'hFF); mw(a, 8'hFF);
            hr(a, v); chk("R10 unmapped host read", v, 0);
            mr(a, v); chk("R10 unmapped mgmt read", v, 0);
        end
        rd_stat(st); chk("R10 status untouched", st, 0);
        hr(5, v); chk("R10 byte 5 untouched", v, 5);
        #1 chk("R10 irqs untouched", int'(host_irq | mgmt_irq), 0);
        mw(15, 8'h01);
        repeat (3) begin
            hr(17, v); chk("R10 read keeps status", v, 8'h80);
            @(negedge clk);
        end
        hw(17, 8'h80);
        hr(17, v); chk("R4 attention cleared", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule